// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block keeps one pending-write bit for every architectural register so that an issue stage can spot read-after-write hazards. When a function unit accepts an instruction that will write a register, that register's bit is set. The bit is cleared again when the unit actually writes the register file. It is also cleared when the unit finishes without ever producing its optional result.

The issue stage presents the source operand addresses of the instruction it is about to send, together with one read flag per operand. The block answers in the same cycle with a single hazard flag. The flag is high when any requested source register still has a write outstanding.

Each unit latches its destination address and write flag at issue. The unit's write-back strobe and its "done without result" condition both clear the latched destination, so the clear side needs no address port of its own. Units that do loads and stores always deliver their result, and a parameter exempts them from the no-result clear path. Registers can be addressed in binary or one-hot form; a parameter picks which.

Top module: `regpend_scoreboard`

## Requirements
- R1: While reset is high, every pending bit becomes 0 at the clock edge, and `pend_o` reads all zeros after reset is released.
- R2: A cycle with `iss_go_i[u]`, `iss_sel_i[u]` and `iss_wflag_i[u]` all high sets the pending bit of `iss_dest_i[u]` at the next clock edge. In binary mode the bit index equals the address value; in one-hot mode the address is used as the mask directly.
- R3: If any one of those three inputs is low, that unit sets no bit. A pending bit never rises unless some unit set it in the previous cycle.
- R4: `wb_en_i[u]` high clears, at the next edge, the bit of the destination that unit latched at its last issue.
- R5: For a unit that is not load/store, a cycle with `fu_done_i[u]` high, `fu_rvalid_i[u]` low and the latched write flag high clears that unit's latched destination bit. When `fu_rvalid_i[u]` is high, `fu_done_i[u]` clears nothing.
- R6: Units marked in the `LDST_UNITS` parameter never clear on `fu_done_i`. By default this is the highest-numbered unit. Their bits clear only through `wb_en_i`.
- R7: The latched write flag and destination load on `iss_go_i & iss_sel_i`. Otherwise the flag drops to 0 in any cycle with `fu_busy_i[u]` low. An issue in the same cycle overrides that drop.
- R8: When a set and a clear hit the same register in one cycle, the bit ends up set.
- R9: `hazard_o` is combinational. It equals `chk_act_i` AND the OR, over every operand `s` with `chk_rden_i[s]` high, of the current pending bit addressed by `chk_src_i[s]`.
- R10: `hazard_o` is 0 whenever `chk_act_i` is low, and operands whose read flag is low never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_go_i | input | NUM_UNITS | Issue strobe per unit |
| iss_sel_i | input | NUM_UNITS | Unit is the one selected for the instruction |
| iss_wflag_i | input | NUM_UNITS | Instruction writes a destination register |
| iss_dest_i | input | NUM_UNITS*AW | Destination address per unit, unit u at bits [u*AW +: AW] |
| fu_busy_i | input | NUM_UNITS | Unit holds an instruction |
| fu_done_i | input | NUM_UNITS | Unit completes its operation |
| fu_rvalid_i | input | NUM_UNITS | Unit's result is valid (a write will happen) |
| wb_en_i | input | NUM_UNITS | Unit writes its destination to the register file |
| chk_act_i | input | 1 | An instruction is being checked for issue |
| chk_rden_i | input | NUM_SRCS | Read flag per source operand |
| chk_src_i | input | NUM_SRCS*AW | Source addresses, operand s at bits [s*AW +: AW] |
| hazard_o | output | 1 | Some requested source has a pending write |
| pend_o | output | NUM_REGS | Pending-write bit vector |

## Verification
The bench drives a set and a clear onto the same register in one cycle. A design that let the clear win would drop a live write and report no hazard while that write is still outstanding. It runs done-without-result both on an ordinary unit and on the load/store unit. Wrong handling there either leaves a register locked forever or frees the load/store destination too early. It lowers busy between issue and done to show that a stale latched flag clears nothing. It also probes the hazard port with inactive operands and an inactive check, where a design that ignored the read flags would stall issue for no reason.

// File: rtl/regpend_pkg.sv
package regpend_pkg;

    typedef enum logic {
        ADDR_BINARY = 1'b0,
        ADDR_ONEHOT = 1'b1
    } addr_mode_e;

    // per-unit issue-time snapshot kept until the unit retires
    typedef struct packed {
        logic wflag;
        logic valid_issue;
    } issue_snap_t;

    function automatic int unsigned addr_width(input int unsigned nregs,
                                               input addr_mode_e mode);
        if (mode == ADDR_ONEHOT)
            return nregs;
        return (nregs > 1) ? $clog2(nregs) : 1;
    endfunction

    // completion with no result while a write was promised
    function automatic logic no_result_clear(input logic done,
                                             input logic lat_wflag,
                                             input logic rvalid);
        return done & lat_wflag & ~rvalid;
    endfunction

endpackage

// File: rtl/regpend_addr_dec.sv
module regpend_addr_dec
    import regpend_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter addr_mode_e  MODE     = ADDR_BINARY,
    parameter int unsigned AW       = addr_width(NUM_REGS, MODE)
) (
    input  logic [AW-1:0]       addr,
    input  logic                en,
    output logic [NUM_REGS-1:0] mask
);

    generate
        if (MODE == ADDR_ONEHOT) begin : g_onehot
            always_comb mask = en ? addr : '0;
        end else begin : g_binary
            localparam logic [NUM_REGS-1:0] ONE = NUM_REGS'(1);
            always_comb mask = en ? (ONE << addr) : '0;
        end
    endgenerate

endmodule

// File: rtl/regpend_unit_track.sv
module regpend_unit_track
    import regpend_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter addr_mode_e  MODE     = ADDR_BINARY,
    parameter int unsigned AW       = addr_width(NUM_REGS, MODE),
    parameter bit          IS_LDST  = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                sel,
    input  logic                wflag,
    input  logic [AW-1:0]       dest,
    input  logic                busy,
    input  logic                done,
    input  logic                rvalid,
    input  logic                wb_en,
    output logic [NUM_REGS-1:0] set_mask,
    output logic [NUM_REGS-1:0] clr_mask
);

    issue_snap_t   snap_q;
    logic [AW-1:0] dest_q;
    logic          take;
    logic          set_en;
    logic          drop_en;
    logic          clr_en;

    assign take    = go & sel;
    assign set_en  = take & wflag;
    assign drop_en = no_result_clear(done, snap_q.wflag, rvalid) & ~IS_LDST;
    assign clr_en  = wb_en | drop_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            dest_q <= '0;
        end else if (take) begin
            snap_q.wflag       <= wflag;
            snap_q.valid_issue <= 1'b1;
            dest_q             <= dest;
        end else if (!busy) begin
            snap_q <= '0;
        end
    end

    regpend_addr_dec #(.NUM_REGS(NUM_REGS), .MODE(MODE), .AW(AW)) i_set_dec (
        .addr (dest),
        .en   (set_en),
        .mask (set_mask)
    );

    regpend_addr_dec #(.NUM_REGS(NUM_REGS), .MODE(MODE), .AW(AW)) i_clr_dec (
        .addr (dest_q),
        .en   (clr_en),
        .mask (clr_mask)
    );

endmodule

// File: rtl/regpend_src_check.sv
module regpend_src_check
    import regpend_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned NUM_SRCS = 3,
    parameter addr_mode_e  MODE     = ADDR_BINARY,
    parameter int unsigned AW       = addr_width(NUM_REGS, MODE)
) (
    input  logic                   active,
    input  logic [NUM_SRCS-1:0]    rden,
    input  logic [NUM_SRCS*AW-1:0] src,
    input  logic [NUM_REGS-1:0]    pend,
    output logic                   hazard
);

    logic [NUM_REGS-1:0] src_mask [NUM_SRCS];
    logic [NUM_REGS-1:0] probe;

    for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
        regpend_addr_dec #(.NUM_REGS(NUM_REGS), .MODE(MODE), .AW(AW)) i_dec (
            .addr (src[s*AW +: AW]),
            .en   (active & rden[s]),
            .mask (src_mask[s])
        );
    end

    always_comb begin
        probe = '0;
        for (int s = 0; s < NUM_SRCS; s++)
            probe = probe | src_mask[s];
    end

    assign hazard = |(probe & pend);

endmodule

// File: rtl/regpend_bits.sv
module regpend_bits #(
    parameter int unsigned NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] set_mask,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (pend & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/regpend_scoreboard.sv
module regpend_scoreboard
    import regpend_pkg::*;
#(
    parameter int unsigned          NUM_REGS   = 32,
    parameter int unsigned          NUM_UNITS  = 3,
    parameter int unsigned          NUM_SRCS   = 3,
    parameter addr_mode_e           MODE       = ADDR_BINARY,
    parameter logic [NUM_UNITS-1:0] LDST_UNITS = {1'b1, {(NUM_UNITS-1){1'b0}}},
    localparam int unsigned         AW         = addr_width(NUM_REGS, MODE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_UNITS-1:0]    iss_go_i,
    input  logic [NUM_UNITS-1:0]    iss_sel_i,
    input  logic [NUM_UNITS-1:0]    iss_wflag_i,
    input  logic [NUM_UNITS*AW-1:0] iss_dest_i,
    input  logic [NUM_UNITS-1:0]    fu_busy_i,
    input  logic [NUM_UNITS-1:0]    fu_done_i,
    input  logic [NUM_UNITS-1:0]    fu_rvalid_i,
    input  logic [NUM_UNITS-1:0]    wb_en_i,
    input  logic                    chk_act_i,
    input  logic [NUM_SRCS-1:0]     chk_rden_i,
    input  logic [NUM_SRCS*AW-1:0]  chk_src_i,
    output logic                    hazard_o,
    output logic [NUM_REGS-1:0]     pend_o
);

    logic [NUM_REGS-1:0] unit_set [NUM_UNITS];
    logic [NUM_REGS-1:0] unit_clr [NUM_UNITS];
    logic [NUM_REGS-1:0] set_all;
    logic [NUM_REGS-1:0] clr_all;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        regpend_unit_track #(
            .NUM_REGS (NUM_REGS),
            .MODE     (MODE),
            .AW       (AW),
            .IS_LDST  (LDST_UNITS[u])
        ) i_track (
            .clk      (clk),
            .rst      (rst),
            .go       (iss_go_i[u]),
            .sel      (iss_sel_i[u]),
            .wflag    (iss_wflag_i[u]),
            .dest     (iss_dest_i[u*AW +: AW]),
            .busy     (fu_busy_i[u]),
            .done     (fu_done_i[u]),
            .rvalid   (fu_rvalid_i[u]),
            .wb_en    (wb_en_i[u]),
            .set_mask (unit_set[u]),
            .clr_mask (unit_clr[u])
        );
    end

    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            set_all = set_all | unit_set[u];
            clr_all = clr_all | unit_clr[u];
        end
    end

    regpend_bits #(.NUM_REGS(NUM_REGS)) i_bits (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_all),
        .clr_mask (clr_all),
        .pend     (pend_o)
    );

    regpend_src_check #(
        .NUM_REGS (NUM_REGS),
        .NUM_SRCS (NUM_SRCS),
        .MODE     (MODE),
        .AW       (AW)
    ) i_check (
        .active (chk_act_i),
        .rden   (chk_rden_i),
        .src    (chk_src_i),
        .pend   (pend_o),
        .hazard (hazard_o)
    );

endmodule

// File: rtl/regpend_checker.sv
module regpend_checker #(
    parameter int unsigned NUM_REGS  = 32,
    parameter int unsigned NUM_UNITS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_UNITS-1:0] iss_go_i,
    input logic [NUM_UNITS-1:0] iss_sel_i,
    input logic [NUM_UNITS-1:0] iss_wflag_i,
    input logic                 chk_act_i,
    input logic                 hazard_o,
    input logic [NUM_REGS-1:0]  pend_o,
    input logic [NUM_REGS-1:0]  set_all,
    input logic [NUM_REGS-1:0]  clr_all
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (pend_o == '0));

    assert_idle_no_hazard_R10: assert property (@(posedge clk) disable iff (rst)
        !chk_act_i |-> !hazard_o);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        assert_issue_sets_R2: assert property (@(posedge clk) disable iff (rst)
            (iss_go_i[u] && iss_sel_i[u] && iss_wflag_i[u]) |-> (set_all != '0));
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            set_all[i] |=> pend_o[i]);
        assert_clear_takes_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_all[i] && !set_all[i]) |=> !pend_o[i]);
        assert_rise_needs_set_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_o[i]) |-> $past(set_all[i]));
    end

endmodule

bind regpend_scoreboard regpend_checker #(
    .NUM_REGS  (NUM_REGS),
    .NUM_UNITS (NUM_UNITS)
) i_regpend_checker (
    .clk         (clk),
    .rst         (rst),
    .iss_go_i    (iss_go_i),
    .iss_sel_i   (iss_sel_i),
    .iss_wflag_i (iss_wflag_i),
    .chk_act_i   (chk_act_i),
    .hazard_o    (hazard_o),
    .pend_o      (pend_o),
    .set_all     (set_all),
    .clr_all     (clr_all)
);

// File: tb/test_regpend_scoreboard.sv
module test_regpend_scoreboard;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;
    localparam int NU = 3;
    localparam int NS = 3;
    localparam int AW = 5;
    localparam logic [NU-1:0] LDST = 3'b100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NU-1:0]    iss_go, iss_sel, iss_wflag, fu_busy, fu_done, fu_rvalid, wb_en;
    logic [NU*AW-1:0] iss_dest;
    logic             chk_act;
    logic [NS-1:0]    chk_rden;
    logic [NS*AW-1:0] chk_src;
    logic             hazard;
    logic [NR-1:0]    pend;

    int n_chk = 0;
    int n_bad = 0;

    logic [NR-1:0] m_pend;
    logic          m_lwf   [NU];
    logic [AW-1:0] m_ldest [NU];

    always #(CLK_PERIOD/2) clk = ~clk;

    regpend_scoreboard i_regpend_scoreboard (
        .clk         (clk),
        .rst         (rst),
        .iss_go_i    (iss_go),
        .iss_sel_i   (iss_sel),
        .iss_wflag_i (iss_wflag),
        .iss_dest_i  (iss_dest),
        .fu_busy_i   (fu_busy),
        .fu_done_i   (fu_done),
        .fu_rvalid_i (fu_rvalid),
        .wb_en_i     (wb_en),
        .chk_act_i   (chk_act),
        .chk_rden_i  (chk_rden),
        .chk_src_i   (chk_src),
        .hazard_o    (hazard),
        .pend_o      (pend)
    );

    function automatic logic [NR-1:0] onehot(input logic [AW-1:0] a);
        logic [NR-1:0] one = NR'(1);
        return one << a;
    endfunction

    function automatic logic exp_hazard();
        logic [NR-1:0] m = '0;
        for (int s = 0; s < NS; s++)
            if (chk_rden[s]) m = m | onehot(chk_src[s*AW +: AW]);
        return chk_act && ((m & m_pend) != '0);
    endfunction

    task automatic idle_inputs();
        iss_go = '0; iss_sel = '0; iss_wflag = '0; iss_dest = '0;
        fu_busy = '1; fu_done = '0; fu_rvalid = '0; wb_en = '0;
        chk_act = 1'b0; chk_rden = '0; chk_src = '0;
    endtask

    task automatic issue(input int u, input logic [AW-1:0] d);
        iss_go[u] = 1'b1; iss_sel[u] = 1'b1; iss_wflag[u] = 1'b1;
        iss_dest[u*AW +: AW] = d;
    endtask

    // inputs are driven; compare outputs, then advance the model
    task automatic step(input string tag);
        logic [NR-1:0] s_m, c_m;
        logic eh;
        #1;
        n_chk++;
        if (pend !== m_pend) begin
            n_bad++;
            $display("FAIL %s pending: actual %h expected %h", tag, pend, m_pend);
        end
        eh = exp_hazard();
        n_chk++;
        if (hazard !== eh) begin
            n_bad++;
            $display("FAIL %s hazard: actual %b expected %b", tag, hazard, eh);
        end
        s_m = '0; c_m = '0;
        for (int u = 0; u < NU; u++) begin
            if (iss_go[u] && iss_sel[u] && iss_wflag[u]) s_m = s_m | onehot(iss_dest[u*AW +: AW]);
            if (wb_en[u]) c_m = c_m | onehot(m_ldest[u]);
            if (!LDST[u] && fu_done[u] && m_lwf[u] && !fu_rvalid[u]) c_m = c_m | onehot(m_ldest[u]);
        end
        for (int u = 0; u < NU; u++) begin
            if (iss_go[u] && iss_sel[u]) begin
                m_lwf[u] = iss_wflag[u];
                m_ldest[u] = iss_dest[u*AW +: AW];
            end else if (!fu_busy[u]) begin
                m_lwf[u] = 1'b0;
            end
        end
        m_pend = (m_pend & ~c_m) | s_m;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_bit(input string tag, input int idx, input logic v);
        n_chk++;
        if (pend[idx] !== v) begin
            n_bad++;
            $display("FAIL %s bit %0d: actual %b expected %b", tag, idx, pend[idx], v);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        idle_inputs();
        m_pend = '0;
        for (int u = 0; u < NU; u++) begin m_lwf[u] = 1'b0; m_ldest[u] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step("R1");

        // R2: issue sets the bit
        issue(0, 5'd5); step("R2");
        step("R2"); expect_bit("R2", 5, 1'b1);

        // R3: any gating input low -> no set
        issue(1, 5'd7); iss_wflag[1] = 1'b0; step("R3");
        issue(1, 5'd8); iss_sel[1] = 1'b0; step("R3");
        issue(1, 5'd9); iss_go[1] = 1'b0; step("R3");
        expect_bit("R3", 7, 1'b0); expect_bit("R3", 8, 1'b0); expect_bit("R3", 9, 1'b0);

        // R9 / R10: hazard port
        chk_act = 1'b1; chk_rden = 3'b010; chk_src[1*AW +: AW] = 5'd5; step("R9");
        chk_act = 1'b1; chk_rden = 3'b111; chk_src = {5'd6, 5'd4, 5'd3}; step("R9");
        chk_act = 1'b1; chk_rden = 3'b101; chk_src = {5'd1, 5'd5, 5'd2}; step("R10");
        chk_act = 1'b0; chk_rden = 3'b111; chk_src = {5'd5, 5'd5, 5'd5}; step("R10");

        // R4: write-back clears latched destination
        wb_en[0] = 1'b1; step("R4");
        step("R4"); expect_bit("R4", 5, 1'b0);

        // R8: set and clear on one register in one cycle
        issue(0, 5'd9); step("R8");
        wb_en[0] = 1'b1; issue(1, 5'd9); step("R8");
        step("R8"); expect_bit("R8", 9, 1'b1);
        wb_en[1] = 1'b1; step("R8");

        // R5: done without result clears; with result does not
        issue(0, 5'd12); step("R5");
        fu_done[0] = 1'b1; fu_rvalid[0] = 1'b1; step("R5");
        expect_bit("R5", 12, 1'b1);
        fu_done[0] = 1'b1; fu_rvalid[0] = 1'b0; step("R5");
        expect_bit("R5", 12, 1'b0);

        // R6: load/store unit exempt
        issue(2, 5'd14); step("R6");
        fu_done[2] = 1'b1; fu_rvalid[2] = 1'b0; step("R6");
        expect_bit("R6", 14, 1'b1);
        wb_en[2] = 1'b1; step("R6");

        // R7: busy low drops latched flag; issue overrides drop
        issue(0, 5'd20); step("R7");
        fu_busy[0] = 1'b0; step("R7");
        fu_done[0] = 1'b1; step("R7");
        expect_bit("R7", 20, 1'b1);
        issue(1, 5'd21); fu_busy[1] = 1'b0; step("R7");
        fu_done[1] = 1'b1; step("R7");
        expect_bit("R7", 21, 1'b0);
        wb_en[0] = 1'b1; step("R7");

        // randomised mix
        for (int k = 0; k < 3000; k++) begin
            for (int u = 0; u < NU; u++) begin
                iss_go[u]    = ($urandom % 4) == 0;
                iss_sel[u]   = ($urandom % 4) != 0;
                iss_wflag[u] = ($urandom % 4) != 0;
                iss_dest[u*AW +: AW] = AW'($urandom % 8);
                fu_busy[u]   = ($urandom % 8) != 0;
                fu_done[u]   = ($urandom % 6) == 0;
                fu_rvalid[u] = ($urandom % 2) == 0;
                wb_en[u]     = ($urandom % 5) == 0;
            end
            chk_act  = ($urandom % 2) == 0;
            chk_rden = NS'($urandom);
            for (int s = 0; s < NS; s++) chk_src[s*AW +: AW] = AW'($urandom % 8);
            step("R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule